// File: doc/BRIEF.md
# Watermark Cache Flush Controller

This block sets how hard a write cache works to commit its dirty pages to the backing store. Each cycle it compares the count of dirty pages with the cache capacity and with two programmable thresholds, a high mark and a low mark. From that comparison it picks one of three flushing modes. In the gentle mode it paces destage requests slowly. In the elevated mode it paces them faster. In the full mode it issues one request every cycle and tells the host side to stop accepting writes.

The elevated mode has hysteresis. It begins once the dirty count reaches the high mark and continues until the count has fallen to the low mark. If the thresholds are programmed so that the low mark is not below the high mark, the controller flags a configuration error and stays in the gentle mode.

A bound on in-flight requests prevents the destage path from being flooded. Each request takes one slot, and each completion pulse from the backend returns one slot. Choosing which page to write and moving the data are the job of neighbouring blocks.

Top module: `wm_flush_ctrl`

## Requirements
- R1: After reset the mode output is 0 (gentle), and both `destage_req` and `host_stall` are low.
- R2: In gentle mode (0), a dirty count at or above `hi_mark` switches the mode to elevated (1) on the next clock edge. A count below `hi_mark` keeps the mode at 0.
- R3: In elevated mode (1), the mode holds at 1 while the count stays above `lo_mark` and below capacity. It returns to 0 on the edge after the count is at or below `lo_mark`.
- R4: A dirty count at or above `capacity` selects full mode (2) on the next edge, and `host_stall` is high while the mode is 2. When the count drops below capacity, the mode leaves 2 on the next edge: to 1 if the count is above `lo_mark`, otherwise to 0.
- R5: In steady gentle mode, exactly one destage request is issued every IDLE_GAP cycles (default 64).
- R6: In steady elevated mode, exactly one destage request is issued every HIGH_GAP cycles (default 8).
- R7: In steady full mode, a destage request is issued every FORCE_GAP cycles (default 1, meaning every cycle).
- R8: While the dirty count is zero, no destage request is issued in any mode.
- R9: When `lo_mark` is greater than or equal to `hi_mark`, `cfg_err` is high and the mode is forced to 0 on the next edge. This holds even at full capacity, and `host_stall` stays low.
- R10: At most MAX_OUT requests (default 4) may be outstanding without a matching `destage_done` pulse. Each `destage_done` pulse allows exactly one further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dirty_cnt | input | W | Number of dirty pages |
| capacity | input | W | Total page count of the cache |
| hi_mark | input | W | Count at which elevated flushing begins |
| lo_mark | input | W | Count at which elevated flushing ends |
| destage_done | input | 1 | One-cycle pulse when a destage completes |
| mode | output | 2 | 0 gentle, 1 elevated, 2 full |
| destage_req | output | 1 | One-cycle destage request strobe |
| host_stall | output | 1 | Host writes must be held off |
| cfg_err | output | 1 | Thresholds are inconsistent |

## Verification
The checker tests the mode transitions on every cycle:
- entry into the elevated and full modes;
- holding the elevated mode inside the hysteresis band;
- the fall back to gentle mode once a configuration error is seen;
- the absence of requests after a cycle with zero dirty pages;
- the tie between the stall output and full mode.

Request pacing is measured only by the bench. It counts strobes over long windows in each mode. It also shows the in-flight limit: with completions withheld, requests stop after MAX_OUT, and a single completion pulse releases exactly one more.

// File: rtl/fc_pkg.sv
package fc_pkg;
   typedef enum logic [1:0] {
      FM_IDLE   = 2'd0,
      FM_HIGH   = 2'd1,
      FM_FORCED = 2'd2
   } flush_mode_e;
endpackage

// File: rtl/fc_mode_fsm.sv
module fc_mode_fsm
   import fc_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] dirty,
   input  logic [W-1:0] cap,
   input  logic [W-1:0] hi,
   input  logic [W-1:0] lo,
   output flush_mode_e  mode_q,
   output logic         bad_cfg
);
   flush_mode_e mode_d;

   assign bad_cfg = (lo >= hi);

   always_comb begin
      mode_d = mode_q;
      if (bad_cfg) begin
         mode_d = FM_IDLE;
      end else if (dirty >= cap) begin
         mode_d = FM_FORCED;
      end else if (mode_q == FM_IDLE) begin
         mode_d = (dirty >= hi) ? FM_HIGH : FM_IDLE;
      end else begin
         mode_d = (dirty <= lo) ? FM_IDLE : FM_HIGH;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= FM_IDLE;
      else        mode_q <= mode_d;
   end
endmodule

// File: rtl/fc_pacer.sv
module fc_pacer
   import fc_pkg::*;
#(
   parameter int IDLE_GAP  = 64,
   parameter int HIGH_GAP  = 8,
   parameter int FORCE_GAP = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  flush_mode_e mode,
   input  logic        has_dirty,
   input  logic        slot_ok,
   output logic        fire,
   output logic        req_q
);
   localparam int CW = $clog2(IDLE_GAP + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] gap_m1;
   flush_mode_e   last_q;
   logic          due;

   always_comb begin
      case (mode)
         FM_HIGH:   gap_m1 = CW'(HIGH_GAP - 1);
         FM_FORCED: gap_m1 = CW'(FORCE_GAP - 1);
         default:   gap_m1 = CW'(IDLE_GAP - 1);
      endcase
   end

   assign due  = (cnt_q >= gap_m1) && (mode == last_q);
   assign fire = due && has_dirty && slot_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         last_q <= FM_IDLE;
         req_q  <= 1'b0;
      end else begin
         last_q <= mode;
         req_q  <= fire;
         if (mode != last_q || fire) cnt_q <= '0;
         else if (cnt_q < gap_m1)    cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/fc_credit.sv
module fc_credit #(
   parameter int MAX_OUT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic done,
   output logic slot_ok
);
   generate
      if (MAX_OUT == 0) begin : g_unbounded
         logic unused_pins;
         assign unused_pins = clk ^ rst_n ^ fire ^ done;
         assign slot_ok = 1'b1;
      end else begin : g_bounded
         localparam int OW = $clog2(MAX_OUT + 1);
         logic [OW-1:0] out_q;
         logic          ret;
         assign ret     = done && (out_q != '0);
         assign slot_ok = (out_q < OW'(MAX_OUT));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else if (fire && !ret) out_q <= out_q + 1'b1;
            else if (!fire && ret) out_q <= out_q - 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/wm_flush_ctrl.sv
module wm_flush_ctrl
   import fc_pkg::*;
#(
   parameter int W         = 8,
   parameter int IDLE_GAP  = 64,
   parameter int HIGH_GAP  = 8,
   parameter int FORCE_GAP = 1,
   parameter int MAX_OUT   = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] dirty_cnt,
   input  logic [W-1:0] capacity,
   input  logic [W-1:0] hi_mark,
   input  logic [W-1:0] lo_mark,
   input  logic         destage_done,
   output logic [1:0]   mode,
   output logic         destage_req,
   output logic         host_stall,
   output logic         cfg_err
);
   generate
      if (!(IDLE_GAP >= HIGH_GAP && HIGH_GAP >= FORCE_GAP && FORCE_GAP >= 1)) begin : g_bad_gaps
         $error("gaps must satisfy IDLE_GAP >= HIGH_GAP >= FORCE_GAP >= 1");
      end
      if (W < 1 || MAX_OUT < 0) begin : g_bad_sizes
         $error("W must be positive and MAX_OUT non-negative");
      end
   endgenerate

   flush_mode_e mode_q;
   logic        fire;
   logic        slot_ok;

   fc_mode_fsm #(.W(W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .dirty(dirty_cnt), .cap(capacity),
      .hi(hi_mark), .lo(lo_mark), .mode_q(mode_q), .bad_cfg(cfg_err)
   );

   fc_pacer #(.IDLE_GAP(IDLE_GAP), .HIGH_GAP(HIGH_GAP), .FORCE_GAP(FORCE_GAP)) u_pace (
      .clk(clk), .rst_n(rst_n), .mode(mode_q), .has_dirty(dirty_cnt != '0),
      .slot_ok(slot_ok), .fire(fire), .req_q(destage_req)
   );

   fc_credit #(.MAX_OUT(MAX_OUT)) u_credit (
      .clk(clk), .rst_n(rst_n), .fire(fire), .done(destage_done), .slot_ok(slot_ok)
   );

   assign mode       = mode_q;
   assign host_stall = (mode_q == FM_FORCED);
endmodule

// File: rtl/fc_flush_chk.sv
module fc_flush_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] dirty_cnt,
   input logic [W-1:0] capacity,
   input logic [W-1:0] hi_mark,
   input logic [W-1:0] lo_mark,
   input logic [1:0]   mode,
   input logic         destage_req,
   input logic         host_stall,
   input logic         cfg_err
);
   // R2
   rise_to_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && !cfg_err && dirty_cnt >= hi_mark && dirty_cnt < capacity) |=> mode == 2'd1);

   // R3
   band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && lo_mark < hi_mark && dirty_cnt > lo_mark && dirty_cnt < capacity) |=> mode == 2'd1);

   // R4
   full_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_mark < hi_mark && dirty_cnt >= capacity) |=> (mode == 2'd2 && host_stall));

   // R4
   stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_stall |-> mode == 2'd2);

   // R8
   no_req_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_cnt == '0) |=> !destage_req);

   // R9
   bad_cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> (mode == 2'd0 && !host_stall));

   // R1
   legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3);
endmodule

bind wm_flush_ctrl fc_flush_chk #(.W(W)) u_chk (.*);

// File: tb/wm_flush_ctrl_bench.sv
`timescale 1ns/1ps
module wm_flush_ctrl_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] dirty_cnt = '0, capacity = 8'd200, hi_mark = 8'd150, lo_mark = 8'd50;
   logic         auto_en = 1'b1, auto_done = 1'b0, man_done = 1'b0;
   logic         destage_done;
   logic [1:0]   mode;
   logic         destage_req, host_stall, cfg_err;
   int           n_vec = 0, n_bad = 0, reqs = 0;

   always #2.5 clk = ~clk;

   assign destage_done = auto_en ? auto_done : man_done;

   wm_flush_ctrl u_wm_flush_ctrl (
      .clk(clk), .rst_n(rst_n), .dirty_cnt(dirty_cnt), .capacity(capacity),
      .hi_mark(hi_mark), .lo_mark(lo_mark), .destage_done(destage_done),
      .mode(mode), .destage_req(destage_req), .host_stall(host_stall), .cfg_err(cfg_err)
   );

   always @(negedge clk) begin
      auto_done <= destage_req;
      if (destage_req) reqs <= reqs + 1;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_dirty(input int v);
      dirty_cnt = W'(v);
      step(1);
   endtask

   task automatic count_window(input int n, output int got);
      int start;
      step(1);
      start = reqs;
      step(n);
      got = reqs - start;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      dirty_cnt = '0; capacity = 8'd200; hi_mark = 8'd150; lo_mark = 8'd50;
      step(3);
      chk(mode == 2'd0, "R1 mode", mode, 0);
      chk(!destage_req && !host_stall, "R1 req/stall", {destage_req, host_stall}, 0);
      rst_n = 1'b1;
      step(2);
   endtask

   task automatic t_hyst;
      set_dirty(100);  chk(mode == 2'd0, "R2 below high", mode, 0);
      set_dirty(149);  chk(mode == 2'd0, "R2 just below high", mode, 0);
      set_dirty(150);  chk(mode == 2'd1, "R2 at high", mode, 1);
      set_dirty(100);  chk(mode == 2'd1, "R3 band hold", mode, 1);
      set_dirty(51);   chk(mode == 2'd1, "R3 above low", mode, 1);
      set_dirty(50);   chk(mode == 2'd0, "R3 at low", mode, 0);
      set_dirty(100);  chk(mode == 2'd0, "R3 idle in band", mode, 0);
   endtask

   task automatic t_full;
      set_dirty(200);
      chk(mode == 2'd2, "R4 full", mode, 2);
      chk(host_stall, "R4 stall", host_stall, 1);
      set_dirty(199);
      chk(mode == 2'd1, "R4 leave to elevated", mode, 1);
      chk(!host_stall, "R4 stall released", host_stall, 0);
      set_dirty(200);
      set_dirty(40);
      chk(mode == 2'd0, "R4 leave to gentle", mode, 0);
   endtask

   task automatic t_rates;
      int got;
      set_dirty(100); step(140);
      count_window(256, got);
      chk(got >= 3 && got <= 5, "R5 gentle rate", got, 4);
      set_dirty(160); step(20);
      count_window(256, got);
      chk(got >= 31 && got <= 33, "R6 elevated rate", got, 32);
      set_dirty(220); step(5);
      count_window(256, got);
      chk(got >= 255 && got <= 256, "R7 full rate", got, 256);
      set_dirty(100);
   endtask

   task automatic t_zero;
      int got;
      capacity = 8'd0;
      set_dirty(0); step(2);
      chk(mode == 2'd2, "R8 empty full mode", mode, 2);
      count_window(64, got);
      chk(got == 0, "R8 no requests", got, 0);
      capacity = 8'd200;
      step(3);
   endtask

   task automatic t_cfg;
      int got;
      hi_mark = 8'd100; lo_mark = 8'd150;
      set_dirty(200);
      chk(cfg_err, "R9 flag", cfg_err, 1);
      chk(mode == 2'd0 && !host_stall, "R9 stays gentle", mode, 0);
      set_dirty(120);
      chk(mode == 2'd0, "R9 above high", mode, 0);
      lo_mark = 8'd100;
      step(1);
      chk(cfg_err, "R9 equal marks", cfg_err, 1);
      count_window(130, got);
      chk(got >= 1 && got <= 3, "R9 gentle pacing kept", got, 2);
      hi_mark = 8'd150; lo_mark = 8'd50;
      set_dirty(0);
      chk(!cfg_err, "R9 flag clear", cfg_err, 0);
   endtask

   task automatic t_credit;
      int got;
      set_dirty(0); step(5);
      auto_en = 1'b0; man_done = 1'b0;
      set_dirty(200);
      count_window(20, got);
      chk(got == 4, "R10 cap outstanding", got, 4);
      man_done = 1'b1; step(1); man_done = 1'b0;
      count_window(8, got);
      chk(got == 1, "R10 one slot freed", got, 1);
   endtask

   initial begin
      fork
         begin
            t_reset;
            t_hyst;
            t_full;
            t_rates;
            t_zero;
            t_cfg;
            t_credit;
         end
         begin
            repeat (100000) @(posedge clk);
            chk(1'b0, "watchdog", 0, 1);
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule